// File: doc/BRIEF.md
# Serial Gain-Code Programming Port

This block is the digital control front end of a programmable-gain line driver. A host sends an 8-bit gain word over a three-wire serial link: a data line, a serial clock, and an active-low enable line that frames the word. The bits go into a short shift register. When the enable line returns high, the register contents are committed to a gain latch, and a one-cycle pulse marks the new setting.

The latched 6-bit code is clamped to the usable range 1 to 60. It is presented both as the clamped code and as a signed gain in half-dB steps, for the analog attenuator to consume. A flag shows whether clamping took place.

Two asynchronous level inputs, transmit-enable and an active-low sleep request, are merged into a 2-bit power-mode output. Every serial and mode input is oversampled by a fast system clock through a synchronizer chain. That clock must run at least four times faster than the serial clock.

Top module: `sgc_gain_port`

## Requirements
- R1: While the enable line is low, each rising edge of the serial clock shifts the data bit into the register, most significant bit first, so that the last bit sent becomes the code LSB.
- R2: A low-to-high transition of the enable line copies the register into the gain latch, and `gain_update` is high for exactly one system-clock cycle at that write.
- R3: Serial clock edges that arrive while the enable line is high leave the register untouched. A later commit with no new bits restores the previous code.
- R4: Only the six least significant bits of the 8-bit word are kept. For example, word 8'h4B yields code 11 and word 8'hC0 yields raw code 0.
- R5: Raw codes 61, 62 and 63 produce `gain_code` 60 with `gain_clamped` = 1. Raw code 60 gives 60 with `gain_clamped` = 0.
- R6: Raw code 0 produces `gain_code` 1 with `gain_clamped` = 1. Raw codes 1 to 60 pass through unchanged with `gain_clamped` = 0.
- R7: `gain_hdb` is the two's-complement 8-bit value 2*`gain_code` - 53. Code 1 gives -51 (8'hCD) and code 60 gives 67.
- R8: While reset is applied, the outputs are `gain_code` = 1, `gain_hdb` = -51, `gain_clamped` = 0, `gain_update` = 0 and `pwr_mode` = 2'b00.
- R9: `pwr_mode` is 2'b00 when `sleep_n` is 0, whatever `tx_en` is. It is 2'b01 when `sleep_n` = 1 and `tx_en` = 0, and 2'b10 when both are 1. Each value follows the inputs within three system-clock cycles.
- R10: `gain_code`, `gain_hdb` and `gain_clamped` change only in a cycle where `gain_update` is high. Partially shifted words never reach them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_data | input | 1 | Serial data bit, MSB first |
| ser_den_n | input | 1 | Active-low word framing / commit line |
| tx_en | input | 1 | Transmit enable level, asynchronous |
| sleep_n | input | 1 | Active-low sleep request, asynchronous |
| gain_code | output | 6 | Clamped gain code, 1 to 60 |
| gain_hdb | output | 8 | Signed gain in half-dB units |
| gain_clamped | output | 1 | Latched code was outside 1 to 60 |
| gain_update | output | 1 | One-cycle pulse on every latch write |
| pwr_mode | output | 2 | 00 sleep, 01 transmit off, 10 transmit on |

## Verification
The words sent are chosen so that each one separates the intended behaviour from a likely mistake:
- An asymmetric word (8'h05) tells MSB-first shifting apart from LSB-first shifting.
- Words with set upper bits (8'h4B, 8'hC0) show that truncation happens rather than saturation.
- Raw codes 0, 1, 60, 61, 62 and 63 sit on both sides of each clamp boundary and exercise the flag.

Serial clock pulses sent with the enable line high, followed by a bare commit, show that the register was frozen. The gain outputs are compared after every bit to show that nothing leaks before the commit. All four combinations of the sleep and transmit-enable levels are applied to tell the sleep override apart from the plain transmit gate.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
   typedef enum logic [1:0] {
      PM_SLEEP  = 2'b00,
      PM_TX_OFF = 2'b01,
      PM_TX_ON  = 2'b10
   } pwr_mode_e;

   // bit positions inside the synchronized input bundle
   localparam int IDX_SLEEP = 0;
   localparam int IDX_TXEN  = 1;
   localparam int IDX_DEN   = 2;
   localparam int IDX_SCLK  = 3;
   localparam int IDX_SDATA = 4;
   localparam int BUNDLE_W  = 5;
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
   parameter int          W      = 1,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sgc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= INIT;
            else        stage[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= INIT;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sgc_shifter.sv
module sgc_shifter #(
   parameter int CODE_W     = 6,
   parameter int RESET_CODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdata_s,
   input  logic              den_s,
   output logic [CODE_W-1:0] latch_q,
   output logic              upd
);
   logic              sclk_d, den_d;
   logic [CODE_W-1:0] shreg;
   logic              sclk_rise, den_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign den_rise  = den_s & ~den_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         den_d   <= 1'b1;
         shreg   <= '0;
         latch_q <= CODE_W'(RESET_CODE);
         upd     <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         den_d  <= den_s;
         upd    <= den_rise;
         if (den_rise) begin
            latch_q <= shreg;
         end else if (sclk_rise && !den_s) begin
            shreg <= {shreg[CODE_W-2:0], sdata_s};
         end
      end
   end
endmodule

// File: rtl/sgc_decode.sv
module sgc_decode #(
   parameter int CODE_W     = 6,
   parameter int CODE_MIN   = 1,
   parameter int CODE_MAX   = 60,
   parameter int HDB_W      = 8,
   parameter int HDB_OFFSET = 53
) (
   input  logic [CODE_W-1:0] raw,
   output logic [CODE_W-1:0] code,
   output logic [HDB_W-1:0]  hdb,
   output logic              clamped
);
   localparam logic [CODE_W-1:0] LO = CODE_W'(CODE_MIN);
   localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_MAX);
   localparam int PAD_W = HDB_W - CODE_W - 1;

   if (PAD_W < 1) begin : g_bad_hdb
      $error("sgc_decode: HDB_W must exceed CODE_W by at least 2");
   end
   if (CODE_MIN > CODE_MAX) begin : g_bad_range
      $error("sgc_decode: CODE_MIN above CODE_MAX");
   end

   always_comb begin
      if (raw < LO) begin
         code    = LO;
         clamped = 1'b1;
      end else if (raw > HI) begin
         code    = HI;
         clamped = 1'b1;
      end else begin
         code    = raw;
         clamped = 1'b0;
      end
      hdb = {{PAD_W{1'b0}}, code, 1'b0} - HDB_W'(HDB_OFFSET);
   end
endmodule

// File: rtl/sgc_gain_port.sv
module sgc_gain_port #(
   parameter int CODE_W      = 6,
   parameter int CODE_MIN    = 1,
   parameter int CODE_MAX    = 60,
   parameter int RESET_CODE  = 1,
   parameter int HDB_W       = 8,
   parameter int HDB_OFFSET  = 53,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_den_n,
   input  logic              tx_en,
   input  logic              sleep_n,
   output logic [CODE_W-1:0] gain_code,
   output logic [HDB_W-1:0]  gain_hdb,
   output logic              gain_clamped,
   output logic              gain_update,
   output logic [1:0]        pwr_mode
);
   import sgc_pkg::*;

   localparam logic [BUNDLE_W-1:0] SYNC_INIT = BUNDLE_W'(1) << IDX_DEN;

   if (CODE_W < 2) begin : g_bad_code_w
      $error("sgc_gain_port: CODE_W must be at least 2");
   end

   logic [BUNDLE_W-1:0] raw_in, syn;
   logic [CODE_W-1:0]   latch_q;
   pwr_mode_e           mode;

   always_comb begin
      raw_in            = '0;
      raw_in[IDX_SLEEP] = sleep_n;
      raw_in[IDX_TXEN]  = tx_en;
      raw_in[IDX_DEN]   = ser_den_n;
      raw_in[IDX_SCLK]  = ser_clk;
      raw_in[IDX_SDATA] = ser_data;
   end

   sgc_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   sgc_shifter #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(syn[IDX_SCLK]), .sdata_s(syn[IDX_SDATA]), .den_s(syn[IDX_DEN]),
      .latch_q(latch_q), .upd(gain_update)
   );

   sgc_decode #(.CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX),
                .HDB_W(HDB_W), .HDB_OFFSET(HDB_OFFSET)) u_dec (
      .raw(latch_q), .code(gain_code), .hdb(gain_hdb), .clamped(gain_clamped)
   );

   always_comb begin
      if (!syn[IDX_SLEEP])     mode = PM_SLEEP;
      else if (!syn[IDX_TXEN]) mode = PM_TX_OFF;
      else                     mode = PM_TX_ON;
   end
   assign pwr_mode = mode;
endmodule

// File: rtl/sgc_gain_port_chk.sv
module sgc_gain_port_chk #(
   parameter int CODE_W   = 6,
   parameter int CODE_MIN = 1,
   parameter int CODE_MAX = 60,
   parameter int HDB_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              sleep_n,
   input logic [CODE_W-1:0] gain_code,
   input logic [HDB_W-1:0]  gain_hdb,
   input logic              gain_clamped,
   input logic              gain_update,
   input logic [1:0]        pwr_mode
);
   assert_update_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gain_update |=> !gain_update);

   assert_code_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_code >= CODE_W'(CODE_MIN)) && (gain_code <= CODE_W'(CODE_MAX)));

   assert_clamp_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gain_clamped |-> (gain_code == CODE_W'(CODE_MIN) || gain_code == CODE_W'(CODE_MAX)));

   assert_hdb_follows_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(gain_hdb) == $signed(HDB_W'(2 * gain_code) - HDB_W'(53)));

   assert_no_change_without_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(gain_code) || !$stable(gain_clamped)) |-> gain_update);

   assert_sleep_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_n && !$past(sleep_n) && !$past(sleep_n, 2) && !$past(sleep_n, 3))
      |-> pwr_mode == 2'b00);

   assert_tx_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && tx_en && $past(sleep_n) && $past(tx_en) && $past(sleep_n, 2) && $past(tx_en, 2)
       && $past(sleep_n, 3) && $past(tx_en, 3)) |-> pwr_mode == 2'b10);
endmodule

bind sgc_gain_port sgc_gain_port_chk #(
   .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .HDB_W(HDB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sleep_n(sleep_n),
   .gain_code(gain_code), .gain_hdb(gain_hdb), .gain_clamped(gain_clamped),
   .gain_update(gain_update), .pwr_mode(pwr_mode)
);

// File: tb/sgc_gain_port_tb.sv
module sgc_gain_port_tb;
   logic       clk = 1'b0;
   logic       rst_n, ser_clk, ser_data, ser_den_n, tx_en, sleep_n;
   logic [5:0] gain_code;
   logic [7:0] gain_hdb;
   logic       gain_clamped, gain_update;
   logic [1:0] pwr_mode;

   int total = 0;
   int bad   = 0;
   logic [5:0] cur_code;

   typedef struct packed {
      logic [5:0] code;
      logic [7:0] hdb;
      logic       clamp;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];

   always #10 clk = ~clk;

   sgc_gain_port u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_den_n(ser_den_n), .tx_en(tx_en), .sleep_n(sleep_n),
      .gain_code(gain_code), .gain_hdb(gain_hdb), .gain_clamped(gain_clamped),
      .gain_update(gain_update), .pwr_mode(pwr_mode)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [7:0] word);
      exp_t e;
      logic [5:0] c;
      c = word[5:0];
      e.clamp = 1'b0;
      if (c == 6'd0)      begin c = 6'd1;  e.clamp = 1'b1; end
      else if (c > 6'd60) begin c = 6'd60; e.clamp = 1'b1; end
      e.code = c;
      e.hdb  = 8'(2 * int'(c) - 53);
      return e;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && gain_update) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2", "unexpected gain_update", 1, 0);
         end else begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(gain_code == e.code, t, "gain_code", int'(gain_code), int'(e.code));
            check(gain_hdb == e.hdb, "R7", "gain_hdb", int'($signed(gain_hdb)), int'($signed(e.hdb)));
            check(gain_clamped == e.clamp, t, "gain_clamped", int'(gain_clamped), int'(e.clamp));
         end
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic commit(input exp_t e, input string tag);
      ser_den_n = 1'b1;
      expq.push_back(e);
      tagq.push_back(tag);
      wait_cyc(8);
      cur_code = e.code;
   endtask

   task automatic send_word(input logic [7:0] word, input string tag);
      ser_den_n = 1'b0;
      wait_cyc(4);
      for (int b = 7; b >= 0; b--) begin
         ser_data = word[b];
         ser_clk  = 1'b0;
         wait_cyc(4);
         ser_clk  = 1'b1;
         wait_cyc(4);
         // R10: nothing reaches the outputs before the commit
         check(gain_code == cur_code, "R10", "gain_code mid-word",
               int'(gain_code), int'(cur_code));
      end
      ser_clk = 1'b0;
      wait_cyc(4);
      commit(model(word), tag);
   endtask

   task automatic set_power(input logic s, input logic t, input logic [1:0] exp_mode);
      sleep_n = s;
      tx_en   = t;
      wait_cyc(3);
      check(pwr_mode == exp_mode, "R9", "pwr_mode", int'(pwr_mode), int'(exp_mode));
   endtask

   initial begin
      rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_den_n = 1'b1;
      tx_en = 1'b0; sleep_n = 1'b0; cur_code = 6'd1;
      wait_cyc(3);
      check(gain_code == 6'd1, "R8", "reset gain_code", int'(gain_code), 1);
      check(gain_hdb == 8'hCD, "R8", "reset gain_hdb", int'(gain_hdb), 8'hCD);
      check(gain_clamped == 1'b0, "R8", "reset gain_clamped", int'(gain_clamped), 0);
      check(gain_update == 1'b0, "R8", "reset gain_update", int'(gain_update), 0);
      check(pwr_mode == 2'b00, "R8", "reset pwr_mode", int'(pwr_mode), 0);
      rst_n = 1'b1;
      wait_cyc(4);

      send_word(8'h05, "R1");   // MSB-first: 5, not 40
      send_word(8'h4B, "R4");   // truncation to 11
      send_word(8'h3C, "R5");   // 60, unflagged
      send_word(8'h3D, "R5");   // 61 -> 60
      send_word(8'h3E, "R5");   // 62 -> 60
      send_word(8'h3F, "R5");   // 63 -> 60
      send_word(8'h00, "R6");   // 0 -> 1
      send_word(8'h01, "R6");   // 1 unflagged
      send_word(8'hC0, "R4");   // upper bits dropped, raw 0 -> 1
      send_word(8'h2A, "R1");   // 42

      // R3: clocks while enable is high must be ignored
      ser_data = 1'b1;
      for (int k = 0; k < 8; k++) begin
         ser_clk = 1'b1; wait_cyc(4);
         ser_clk = 1'b0; wait_cyc(4);
      end
      check(gain_code == 6'd42, "R3", "code after idle clocks", int'(gain_code), 42);
      ser_den_n = 1'b0;
      wait_cyc(6);
      commit(model(8'h2A), "R3");
      check(gain_code == 6'd42, "R3", "code after bare commit", int'(gain_code), 42);

      set_power(1'b0, 1'b1, 2'b00);
      set_power(1'b0, 1'b0, 2'b00);
      set_power(1'b1, 1'b0, 2'b01);
      set_power(1'b1, 1'b1, 2'b10);
      set_power(1'b0, 1'b1, 2'b00);

      wait_cyc(10);
      check(expq.size() == 0, "R2", "pending expected updates", expq.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule